// File: doc/BRIEF.md
# Write-Through Cache with Deferred Data Commit

This block is a direct-mapped, write-through data cache for word-sized accesses. A store is handled in two steps that overlap with neighbouring stores. When a store arrives, its tag is looked up. If the line is resident, the word is parked in a one-entry holding register. The word only moves into the data array when the next store that hits arrives, and the tag lookup of that newer store takes place in the same cycle. Loads compare their address with the holding register and take the parked word when it matches. A load therefore never sees an older value from the array.

Every store is copied, hit or miss, to a lower-level write path one cycle after it is accepted. A load that misses first empties the holding register into the array. It then requests the whole line on a simple memory port and stalls the processor (`busy`) while the beats arrive. It answers with the requested word in the cycle after the final beat. A store that misses allocates nothing.

Top module: `dwc_cache`

## Requirements
- R1: After reset no line is resident, `busy`, `rsp_valid`, `wt_valid` and `mem_req` are low, and the first load to any address misses.
- R2: A load that hits returns `rsp_valid` with its word in the cycle after it is accepted.
- R3: A load that misses raises `mem_req` for one cycle, with `mem_line_addr` equal to the request address with its two word-offset bits dropped. It holds `busy` high until the fourth beat (beats arrive in word order 0..3) and returns the requested word in the cycle after that beat. The line is resident afterwards.
- R4: Every accepted store, hit or miss, shows `wt_valid` with its address and data in the next cycle, and produces no `rsp_valid`.
- R5: A store that hits is parked and reaches the data array only when a later store hits. Loads to either word return the newest data in that case.
- R6: A load whose index and offset match the parked word returns the parked data, in preference to the array content.
- R7: Loads never move the parked word. Repeated loads keep returning the parked value.
- R8: A store that misses leaves the parked word and residency unchanged. A later load to its line misses and returns the stored value from the lower level.
- R9: A load miss commits a pending parked word to the array before the fill begins. The parked register is empty during the fill, and the committed word is readable from the array afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 10 | Word address: tag[9:6], index[5:2], offset[1:0] |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Line fill in progress; requests are not accepted |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| wt_valid | output | 1 | Write-through word to the lower level |
| wt_addr | output | 10 | Write-through address |
| wt_data | output | 32 | Write-through data |
| mem_req | output | 1 | One-cycle line fill request |
| mem_line_addr | output | 8 | Line address of the fill |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | 32 | Fill beat data |

## Verification
A load hit answers one cycle after acceptance, and a store appears on the write-through port one cycle after acceptance. The bench drives each request on a falling edge and reads these results at the very next falling edge. A miss answers one cycle after the fourth fill beat. The bench's memory model returns the beats two cycles after it sees `mem_req`, so a miss is followed until `rsp_valid` appears. Each response is compared with a behavioural model that tracks residency and the newest written value of every word. Mixed store and load sequences with conflicting lines exercise forwarding, commits and eviction.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } dwc_state_e;

endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  line_vld;
    logic [TAG_W-1:0] line_tag [SETS];

    assign lk_hit = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld <= '0;
        end else if (upd_en) begin
            line_vld[upd_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) begin
            line_tag[upd_idx] <= upd_tag;
        end
    end

    a_r3_fill_makes_resident: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> line_vld[$past(upd_idx)]);

endmodule

// File: rtl/dwc_data_store.sv
module dwc_data_store #(
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int WORDS = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] arr [WORDS];

    assign rd_data = arr[{rd_idx, rd_off}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            arr[{wr_idx, wr_off}] <= wr_data;
        end
    end

endmodule

// File: rtl/dwc_delay_buf.sv
module dwc_delay_buf #(
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              drain,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [OFF_W-1:0]  chk_off,
    output logic              fwd_hit,
    output logic              q_valid,
    output logic [IDX_W-1:0]  q_idx,
    output logic [OFF_W-1:0]  q_off,
    output logic [DATA_W-1:0] q_data
);
    assign fwd_hit = q_valid && (q_idx == chk_idx) && (q_off == chk_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
        end else if (load) begin
            q_valid <= 1'b1;
        end else if (drain) begin
            q_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            q_idx  <= ld_idx;
            q_off  <= ld_off;
            q_data <= ld_data;
        end
    end

    a_r5_park_on_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (q_valid && q_data == $past(ld_data)));

endmodule

// File: rtl/dwc_cache.sv
module dwc_cache
    import dwc_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  IDX_W  = 4,
    parameter int  OFF_W  = 2,
    parameter int  TAG_W  = 4,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
    localparam int LINE_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [DATA_W-1:0] wt_data,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    dwc_state_e state;

    logic [OFF_W-1:0]  a_off;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic              hit;
    logic              acc, wr_hit, rd_hit, rd_miss, commit;
    logic              fill_beat, fill_last;

    logic [TAG_W-1:0]  miss_tag;
    logic [IDX_W-1:0]  miss_idx;
    logic [OFF_W-1:0]  miss_off;
    logic [OFF_W-1:0]  beat;
    logic [DATA_W-1:0] crit_word;

    logic              fwd_hit, dq_valid;
    logic [IDX_W-1:0]  dq_idx;
    logic [OFF_W-1:0]  dq_off;
    logic [DATA_W-1:0] dq_data;

    logic              arr_we;
    logic [IDX_W-1:0]  arr_widx;
    logic [OFF_W-1:0]  arr_woff;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;

    assign {a_tag, a_idx, a_off} = req_addr;
    assign busy    = (state == ST_FILL);
    assign acc     = req_valid && !busy;
    assign wr_hit  = acc && req_write && hit;
    assign rd_hit  = acc && !req_write && hit;
    assign rd_miss = acc && !req_write && !hit;
    assign commit  = dq_valid && (wr_hit || rd_miss);

    assign fill_beat = busy && mem_rvalid;
    assign fill_last = fill_beat && (beat == {OFF_W{1'b1}});

    // Single array write port: fill beats and parked-word commits never overlap.
    always_comb begin
        arr_we    = fill_beat || commit;
        arr_widx  = fill_beat ? miss_idx : dq_idx;
        arr_woff  = fill_beat ? beat : dq_off;
        arr_wdata = fill_beat ? mem_rdata : dq_data;
    end

    dwc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (a_idx),
        .lk_tag  (a_tag),
        .lk_hit  (hit),
        .upd_en  (fill_last),
        .upd_idx (miss_idx),
        .upd_tag (miss_tag)
    );

    dwc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_off  (a_off),
        .rd_data (arr_rdata),
        .wr_en   (arr_we),
        .wr_idx  (arr_widx),
        .wr_off  (arr_woff),
        .wr_data (arr_wdata)
    );

    dwc_delay_buf #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dbuf (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_hit),
        .ld_idx  (a_idx),
        .ld_off  (a_off),
        .ld_data (req_wdata),
        .drain   (commit),
        .chk_idx (a_idx),
        .chk_off (a_off),
        .fwd_hit (fwd_hit),
        .q_valid (dq_valid),
        .q_idx   (dq_idx),
        .q_off   (dq_off),
        .q_data  (dq_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            wt_valid  <= 1'b0;
            mem_req   <= 1'b0;
            beat      <= '0;
        end else begin
            rsp_valid <= rd_hit || fill_last;
            wt_valid  <= acc && req_write;
            mem_req   <= rd_miss;
            if (rd_miss) begin
                state <= ST_FILL;
                beat  <= '0;
            end else if (fill_last) begin
                state <= ST_IDLE;
            end
            if (fill_beat) begin
                beat <= beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc && req_write) begin
            wt_addr <= req_addr;
            wt_data <= req_wdata;
        end
        if (rd_miss) begin
            miss_tag      <= a_tag;
            miss_idx      <= a_idx;
            miss_off      <= a_off;
            mem_line_addr <= {a_tag, a_idx};
        end
        if (fill_beat && beat == miss_off) begin
            crit_word <= mem_rdata;
        end
        if (rd_hit) begin
            rsp_rdata <= fwd_hit ? dq_data : arr_rdata;
        end else if (fill_last) begin
            rsp_rdata <= (beat == miss_off) ? mem_rdata : crit_word;
        end
    end

    a_r4_wt_follows_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !busy) |=> (wt_valid && wt_addr == $past(req_addr)));

    a_r2_hit_answers_next: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> rsp_valid);

    a_r3_miss_starts_fill: assert property (@(posedge clk) disable iff (rst)
        rd_miss |=> (mem_req && busy && !rsp_valid));

    a_r9_empty_during_fill: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dq_valid);

    a_r7_read_keeps_parked: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> ($stable(dq_valid) && $stable(dq_data)));

    a_r8_store_miss_keeps_parked: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !hit) |=> ($stable(dq_valid) && $stable(dq_data)));

endmodule

// File: tb/test_dwc_cache.sv
module test_dwc_cache;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [9:0]  req_addr;
    logic [31:0] req_wdata;
    logic        busy, rsp_valid, wt_valid, mem_req;
    logic [31:0] rsp_rdata, wt_data;
    logic [9:0]  wt_addr;
    logic [7:0]  mem_line_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int failures = 0;
    int fills = 0;
    int last_line = -1;

    logic [31:0] ref_mem [1024];
    logic [31:0] low_mem [1024];
    bit          res_v   [16];
    int          res_tag [16];

    always #2.5 clk = ~clk;

    dwc_cache i_dwc_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data),
        .mem_req(mem_req), .mem_line_addr(mem_line_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lower-level memory absorbs the write-through stream.
    always @(negedge clk) begin
        if (wt_valid) low_mem[wt_addr] = wt_data;
    end

    // Fill responder: four beats in word order, two cycles after the request.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                last_line = int'(mem_line_addr);
                fills++;
                repeat (2) @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = low_mem[{mem_line_addr, b[1:0]}];
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(wt_valid === 1'b1, "R4 wt_valid", {31'd0, wt_valid}, 32'd1);
        check(wt_addr === a, "R4 wt_addr", {22'd0, wt_addr}, {22'd0, a});
        check(wt_data === d, "R4 wt_data", wt_data, d);
        check(rsp_valid === 1'b0, "R4 no response to store", {31'd0, rsp_valid}, 32'd0);
        ref_mem[a] = d;
    endtask

    task automatic do_read(input logic [9:0] a, input string req);
        int  idx = int'(a[5:2]);
        int  tag = int'(a[9:6]);
        bit  exp_hit = res_v[idx] && (res_tag[idx] == tag);
        int  f0 = fills;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            check(rsp_valid === 1'b1, {req, " R2 hit next cycle"}, {31'd0, rsp_valid}, 32'd1);
        end else begin
            check(rsp_valid === 1'b0 && busy === 1'b1, {req, " R3 miss stalls"}, {30'd0, busy, rsp_valid}, 32'd2);
            for (int k = 0; k < 40 && rsp_valid !== 1'b1; k++) @(negedge clk);
            check(rsp_valid === 1'b1, {req, " R3 miss answered"}, {31'd0, rsp_valid}, 32'd1);
            check(fills == f0 + 1, {req, " R3 one fill"}, fills - f0, 32'd1);
            check(last_line == int'(a[9:2]), {req, " R3 line address"}, last_line, {24'd0, a[9:2]});
            check(busy === 1'b0, {req, " R3 busy released"}, {31'd0, busy}, 32'd0);
            res_v[idx] = 1'b1;
            res_tag[idx] = tag;
        end
        check(rsp_rdata === ref_mem[a], {req, " data"}, rsp_rdata, ref_mem[a]);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int s = 7;
        for (int i = 0; i < 1024; i++) begin
            ref_mem[i] = (i * 32'h01010101) ^ 32'hA5000000;
            low_mem[i] = ref_mem[i];
        end
        for (int i = 0; i < 16; i++) begin res_v[i] = 1'b0; res_tag[i] = 0; end
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && rsp_valid === 1'b0 && wt_valid === 1'b0 && mem_req === 1'b0,
              "R1 idle after reset", {28'd0, busy, rsp_valid, wt_valid, mem_req}, 32'd0);

        do_read(10'h010, "R1 cold miss");
        do_read(10'h011, "R2 hit");
        do_write(10'h012, 32'h1111_2222);
        do_read(10'h012, "R6 forward parked");
        do_read(10'h012, "R7 parked stays");
        do_read(10'h013, "R7 other word from array");
        do_write(10'h013, 32'h3333_4444);
        do_read(10'h012, "R5 committed word");
        do_read(10'h013, "R5 newest parked");
        do_write(10'h012, 32'h5555_6666);
        do_write(10'h012, 32'h7777_8888);
        do_read(10'h012, "R5 back-to-back same word");
        do_write(10'h150, 32'h9999_AAAA);
        do_read(10'h012, "R8 parked untouched");
        do_read(10'h150, "R8 no allocate");
        do_read(10'h010, "R9 evicting refill");
        do_write(10'h011, 32'hBBBB_CCCC);
        do_read(10'h024, "R9 miss drains parked");
        do_read(10'h011, "R9 committed before fill");
        do_read(10'h024, "R2 hit after fill");

        for (int n = 0; n < 80; n++) begin
            logic [9:0] a;
            s = s * 1103515245 + 12345;
            a = {3'd0, s[8], s[13:12], s[17:16]} | 10'h100;
            if (s[20]) do_write(a, s ^ 32'h5A5A_0F0F);
            else       do_read(a, "R6 mixed sequence");
        end

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule